// File: doc/BRIEF.md
# Prescaled Event Timer

This block is an 8-bit up-counting timer. It advances from one of two count sources. The first is an instruction-rate enable pulse supplied from outside the block. The second is an external pin, whose active edge is selectable and which is first resynchronised into the clock domain. Every source event advances a free-running prescaler, and a select field chooses one of its taps, so the timer advances once per 2, 4, 8, 16, 32, 64, 128 or 256 events. When the timer rolls over from all ones to zero, it raises a sticky overflow flag that software clears.

Counting stops while the chip sleeps. The one exception is when a conversion is running and the converter's wake permission is set; then counting continues through sleep. A small write port loads the timer, the control fields and the flag-clear command. The timer value, the control fields and the flag are always visible on output ports.

Top module: `tick_timer`

## Requirements
- R1: After reset, the timer value, the control readback and the overflow flag are all zero.
- R2: With prescaler select value s (control bits [4:2]), the timer advances by one for every 2^(s+1) accepted source events, for each s from 0 to 7.
- R3: When an accepted event takes the timer from 8'hFF to 8'h00, the overflow flag is set. The flag stays set until a write to address 2 with data bit 0 equal to 0. A write to address 2 with data bit 0 equal to 1 leaves the flag unchanged.
- R4: With the source bit set (control bit 0), only one kind of external pin edge is counted. Control bit 1 picks which: 0 counts rising edges, 1 counts falling edges.
- R5: A change of the external pin that the clock captures at edge k is counted by the timer at edge k+2, and the timer output shows the new value from that edge.
- R6: While the sleep input is high, the timer does not advance unless both the conversion-busy and wake-enable inputs are high.
- R7: While sleeping with conversion-busy and wake-enable both high, counting continues at the normal rate.
- R8: A write to address 0 loads the timer with the write data at the next edge and clears the prescaler, so that any partial count is discarded.
- R9: The unselected source has no effect. Instruction-tick pulses are ignored when control bit 0 is 1, and pin edges are ignored when it is 0.
- R10: A write to address 1 stores data bits [4:0] as the control fields. The control readback shows them in bits [4:0], with bits [7:5] reading zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| instTick | input | 1 | Instruction-rate count enable pulse |
| extPin | input | 1 | Asynchronous external count pin |
| sleepMode | input | 1 | Chip in sleep |
| convBusy | input | 1 | Conversion in progress |
| wakeEn | input | 1 | Converter wake permission |
| busWe | input | 1 | Write strobe |
| busAddr | input | 2 | Write address: 0 timer, 1 control, 2 flag clear |
| busWdata | input | 8 | Write data |
| tmrValue | output | 8 | Timer value |
| ctrlValue | output | 8 | Control readback |
| ovfFlag | output | 1 | Sticky overflow flag |

## Verification
The bench builds the block with its default widths: an 8-bit timer and a 3-bit select, which gives an 8-bit prescaler. With these widths, all eight division ratios can be stepped through one by one, up to 256 events per timer step. They also keep a full rollover from 8'hFF within a few cycles after a load, and keep the two-stage pin synchronizer latency at an exact, countable number of edges.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;
  localparam logic [1:0] ADDR_TMR  = 2'd0;
  localparam logic [1:0] ADDR_CTRL = 2'd1;
  localparam logic [1:0] ADDR_FLAG = 2'd2;

  typedef struct packed {
    logic tick;     // accepted source event this cycle
    logic loadTmr;  // bus load of the timer, clears the prescaler
    logic clrFlag;  // software clear of the overflow flag
  } tmrStrobe_t;
endpackage

// File: rtl/tick_timer_ctrl.sv
module tick_timer_ctrl
  import tick_timer_pkg::*;
#(
  parameter int SEL_W       = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             instTick,
  input  logic             extPin,
  input  logic             sleepMode,
  input  logic             convBusy,
  input  logic             wakeEn,
  input  logic             busWe,
  input  logic [1:0]       busAddr,
  input  logic [SEL_W+1:0] ctrlWdata,
  output tmrStrobe_t       strobe,
  output logic [SEL_W-1:0] preSel,
  output logic             srcExt,
  output logic             edgeFall
);
  localparam int CW = SEL_W + 2;

  logic [SYNC_STAGES-1:0] syncQ;
  logic pinPrev, pinNow, riseEv, fallEv, srcEvent, runOk, wrTmr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ   <= '0;
      pinPrev <= 1'b0;
    end else begin
      syncQ   <= {syncQ[SYNC_STAGES-2:0], extPin};
      pinPrev <= syncQ[SYNC_STAGES-1];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      srcExt   <= 1'b0;
      edgeFall <= 1'b0;
      preSel   <= '0;
    end else if (busWe && busAddr == ADDR_CTRL) begin
      srcExt   <= ctrlWdata[0];
      edgeFall <= ctrlWdata[1];
      preSel   <= ctrlWdata[CW-1:2];
    end
  end

  always_comb begin
    pinNow   = syncQ[SYNC_STAGES-1];
    riseEv   = pinNow & ~pinPrev;
    fallEv   = ~pinNow & pinPrev;
    srcEvent = srcExt ? (edgeFall ? fallEv : riseEv) : instTick;
    runOk    = ~sleepMode | (convBusy & wakeEn);
    wrTmr    = busWe && (busAddr == ADDR_TMR);
    strobe.loadTmr = wrTmr;
    strobe.tick    = srcEvent & runOk & ~wrTmr;
    strobe.clrFlag = busWe && (busAddr == ADDR_FLAG) && !ctrlWdata[0];
  end
endmodule

// File: rtl/tick_timer_datapath.sv
module tick_timer_datapath
  import tick_timer_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SEL_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  tmrStrobe_t        strobe,
  input  logic [SEL_W-1:0]  preSel,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] tmrValue,
  output logic              ovfFlag
);
  localparam int PRE_W = 1 << SEL_W;

  logic [PRE_W-1:0] preCnt;
  logic [PRE_W-1:0] tapDone;
  logic selDone, tmrInc, wrapNow;

  // tap i completes after 2^(i+1) events: low i+1 bits all ones
  for (genvar i = 0; i < PRE_W; i++) begin : g_tap
    assign tapDone[i] = &preCnt[i:0];
  end

  always_comb begin
    selDone = tapDone[preSel];
    tmrInc  = strobe.tick & selDone;
    wrapNow = tmrInc & (&tmrValue);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt   <= '0;
      tmrValue <= '0;
    end else if (strobe.loadTmr) begin
      preCnt   <= '0;
      tmrValue <= busWdata;
    end else if (strobe.tick) begin
      preCnt <= preCnt + 1'b1;
      if (tmrInc) tmrValue <= tmrValue + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               ovfFlag <= 1'b0;
    else if (wrapNow)        ovfFlag <= 1'b1;
    else if (strobe.clrFlag) ovfFlag <= 1'b0;
  end
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_timer_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SEL_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              instTick,
  input  logic              extPin,
  input  logic              sleepMode,
  input  logic              convBusy,
  input  logic              wakeEn,
  input  logic              busWe,
  input  logic [1:0]        busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] tmrValue,
  output logic [DATA_W-1:0] ctrlValue,
  output logic              ovfFlag
);
  localparam int CW = SEL_W + 2;

  tmrStrobe_t       strobe;
  logic [SEL_W-1:0] preSel;
  logic             srcExt, edgeFall;

  tick_timer_ctrl #(.SEL_W(SEL_W), .SYNC_STAGES(2)) u_ctrl (
    .clk(clk), .rstN(rstN), .instTick(instTick), .extPin(extPin),
    .sleepMode(sleepMode), .convBusy(convBusy), .wakeEn(wakeEn),
    .busWe(busWe), .busAddr(busAddr), .ctrlWdata(busWdata[CW-1:0]),
    .strobe(strobe), .preSel(preSel), .srcExt(srcExt), .edgeFall(edgeFall)
  );

  tick_timer_datapath #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .preSel(preSel),
    .busWdata(busWdata), .tmrValue(tmrValue), .ovfFlag(ovfFlag)
  );

  assign ctrlValue = {{(DATA_W-CW){1'b0}}, preSel, edgeFall, srcExt};
endmodule

// File: rtl/tick_timer_checker.sv
module tick_timer_checker
  import tick_timer_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              sleepMode,
  input logic              convBusy,
  input logic              wakeEn,
  input logic              busWe,
  input logic [1:0]        busAddr,
  input logic [DATA_W-1:0] busWdata,
  input logic [DATA_W-1:0] tmrValue,
  input logic              ovfFlag
);
  logic [DATA_W-1:0] tmrPlus;
  assign tmrPlus = tmrValue + 1'b1;

  p_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    !busWe |=> (tmrValue == $past(tmrValue)) || (tmrValue == $past(tmrPlus)));

  p_load_r8: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == ADDR_TMR) |=> tmrValue == $past(busWdata));

  p_sleep_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (sleepMode && !(convBusy && wakeEn) && !busWe) |=> $stable(tmrValue));

  p_wrap_sets_r3: assert property (@(posedge clk) disable iff (!rstN)
    ((&tmrValue) && !busWe) ##1 (tmrValue == '0) |-> ovfFlag);

  p_flag_sticky_r3: assert property (@(posedge clk) disable iff (!rstN)
    (ovfFlag && !(busWe && busAddr == ADDR_FLAG && !busWdata[0])) |=> ovfFlag);

  p_flag_clear_r3: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == ADDR_FLAG && !busWdata[0] && !(&tmrValue)) |=> !ovfFlag);
endmodule

bind tick_timer tick_timer_checker #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/tick_timer_bench.sv
`timescale 1ns/1ps
module tick_timer_bench;
  logic clk = 1'b0;
  logic rstN, instTick, extPin, sleepMode, convBusy, wakeEn, busWe;
  logic [1:0] busAddr;
  logic [7:0] busWdata, tmrValue, ctrlValue;
  logic ovfFlag;

  always #4 clk = ~clk;

  tick_timer u_tick_timer (.*);

  typedef struct {
    string      tag;
    logic [7:0] tmr;
    logic [7:0] ctrl;
    logic       flag;
  } exp_t;

  exp_t q[$];
  int nTests = 0, nFail = 0;
  logic [7:0] mCtrl = 8'h00;
  bit done = 0;

  // monitor: compare queued expectations half a cycle after the edge
  always @(negedge clk) begin
    while (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      nTests++;
      if (tmrValue !== e.tmr || ctrlValue !== e.ctrl || ovfFlag !== e.flag) begin
        nFail++;
        $display("FAIL %s: tmr=%h ctrl=%h flag=%b expected tmr=%h ctrl=%h flag=%b",
                 e.tag, tmrValue, ctrlValue, ovfFlag, e.tmr, e.ctrl, e.flag);
      end
    end
  end

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic expectNow(string tag, logic [7:0] t, logic f);
    q.push_back('{tag, t, mCtrl, f});
  endtask

  task automatic busWrite(logic [1:0] a, logic [7:0] d);
    busWe = 1'b1; busAddr = a; busWdata = d;
    step(1);
    busWe = 1'b0;
  endtask

  task automatic setCtrl(logic [7:0] d);
    busWrite(2'd1, d);
    mCtrl = d & 8'h1F;
  endtask

  task automatic intTicks(int n);
    for (int i = 0; i < n; i++) begin
      instTick = 1'b1; step(1);
      instTick = 1'b0; step(1);
    end
  endtask

  task automatic setPin(logic v);
    extPin = v;
    step(3);
  endtask

  initial begin
    rstN = 1'b0; instTick = 0; extPin = 0; sleepMode = 0; convBusy = 0;
    wakeEn = 0; busWe = 0; busAddr = 0; busWdata = 0;
    step(3);
    rstN = 1'b1;
    step(1);
    expectNow("R1 reset state", 8'h00, 1'b0);

    // R2: every prescaler ratio
    for (int s = 0; s < 8; s++) begin
      setCtrl(8'(s << 2));
      busWrite(2'd0, 8'h00);
      intTicks((2 << s) - 1);
      expectNow("R2 partial ratio", 8'h00, 1'b0);
      intTicks(1);
      expectNow("R2 full ratio", 8'h01, 1'b0);
    end

    // R8: reload discards partial prescaler count
    setCtrl(8'h04);
    busWrite(2'd0, 8'h05);
    expectNow("R8 load value", 8'h05, 1'b0);
    intTicks(3);
    busWrite(2'd0, 8'h05);
    intTicks(3);
    expectNow("R8 partial discarded", 8'h05, 1'b0);
    intTicks(1);
    expectNow("R8 count after reload", 8'h06, 1'b0);

    // R3: overflow flag
    setCtrl(8'h00);
    busWrite(2'd0, 8'hFF);
    intTicks(2);
    expectNow("R3 wrap sets flag", 8'h00, 1'b1);
    intTicks(4);
    expectNow("R3 flag sticky", 8'h02, 1'b1);
    busWrite(2'd2, 8'h01);
    expectNow("R3 write one keeps flag", 8'h02, 1'b1);
    busWrite(2'd2, 8'h00);
    expectNow("R3 write zero clears flag", 8'h02, 1'b0);

    // R4: rising edge selection
    setCtrl(8'h01);
    busWrite(2'd0, 8'h00);
    setPin(1'b1);
    setPin(1'b0);
    expectNow("R4 rising only counted", 8'h00, 1'b0);
    setPin(1'b1);
    expectNow("R4 second rise counted", 8'h01, 1'b0);
    setPin(1'b0);
    // R4: falling edge selection
    setCtrl(8'h03);
    busWrite(2'd0, 8'h00);
    setPin(1'b1);
    setPin(1'b0);
    setPin(1'b1);
    expectNow("R4 falling only counted", 8'h00, 1'b0);
    setPin(1'b0);
    expectNow("R4 second fall counted", 8'h01, 1'b0);

    // R5: synchronizer latency
    setCtrl(8'h01);
    busWrite(2'd0, 8'h00);
    setPin(1'b1);
    setPin(1'b0);
    extPin = 1'b1;
    step(2);
    expectNow("R5 not yet counted at k+1", 8'h00, 1'b0);
    step(1);
    expectNow("R5 counted at k+2", 8'h01, 1'b0);
    step(2);

    // R9: unselected source ignored
    intTicks(4);
    expectNow("R9 ticks ignored in pin mode", 8'h01, 1'b0);
    extPin = 1'b0; step(3);
    setCtrl(8'h00);
    busWrite(2'd0, 8'h00);
    setPin(1'b1); setPin(1'b0); setPin(1'b1); setPin(1'b0);
    expectNow("R9 pin ignored in tick mode", 8'h00, 1'b0);

    // R6 / R7: sleep gating
    sleepMode = 1'b1;
    intTicks(4);
    expectNow("R6 sleep halts count", 8'h00, 1'b0);
    convBusy = 1'b1;
    intTicks(4);
    expectNow("R6 busy without wake halts", 8'h00, 1'b0);
    convBusy = 1'b0; wakeEn = 1'b1;
    intTicks(4);
    expectNow("R6 wake without busy halts", 8'h00, 1'b0);
    convBusy = 1'b1;
    intTicks(4);
    expectNow("R7 busy and wake keep counting", 8'h02, 1'b0);
    sleepMode = 1'b0; convBusy = 1'b0; wakeEn = 1'b0;
    intTicks(2);
    expectNow("R7 awake counting resumes", 8'h03, 1'b0);

    // R10: control readback
    setCtrl(8'hFF);
    expectNow("R10 control readback", 8'h03, 1'b0);

    step(2);
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      nTests++; nFail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end
endmodule